// File: doc/BRIEF.md
# Synchronous Data Clock Generator

This block derives the bit clock of a synchronous serial modem data port from a fast system clock. A programmable half-period count sets the bit rate: the generated clock stays high for that many system cycles and then low for the same number, so the full bit period is always an even number of system cycles and the duty cycle is exactly one half.

The rising edge of the generated clock marks the centre of each bit. On that edge the block captures the transmit-data line from the terminal and hands the bit to the modem core with a one-cycle strobe. Received bits from the core are launched onto the receive-data line on the falling edge, half a bit before the rising edge at which the terminal samples them. A one-cycle pulse tells the core that its bit was taken. A change of the half-period count is adopted only at a falling edge, so a phase that is already running is never cut short.

Top module: `sdclk_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `dclk_o`, `rxd_o`, `tx_bit_o`, `tx_strobe_o` and `rx_take_o` are all 0.
- R2: Each high phase and each low phase of `dclk_o` lasts exactly H system cycles, where H is the half-period count in effect, so one bit lasts 2H cycles.
- R3: A half-period count of 0 is treated as 1, so the clock toggles on every system cycle.
- R4: A new value on `half_per_i` is latched only in the cycle in which `dclk_o` falls. A high phase already under way finishes with the old count, and the low and high phases that follow both use the new one.
- R5: `tx_strobe_o` is 1 in exactly those cycles in which `dclk_o` has just risen. In those cycles `tx_bit_o` carries the value that `txd_i` had at the clock edge where `dclk_o` went high.
- R6: `rxd_o` changes only in the cycle in which `dclk_o` falls, and then takes the value `rx_bit_i` had at that edge. `rx_take_o` is 1 in exactly those cycles.
- R7: `tx_bit_o` keeps its value in every cycle in which `tx_strobe_o` is 0.
- R8: The largest count, 2^DIV_W-1, gives phases of that full length with no wrap of the internal counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_per_i | input | DIV_W | Half bit period in system cycles (0 acts as 1) |
| txd_i | input | 1 | Transmit data from the terminal |
| rx_bit_i | input | 1 | Next received bit from the modem core |
| dclk_o | output | 1 | Generated bit clock |
| rxd_o | output | 1 | Received data towards the terminal |
| tx_bit_o | output | 1 | Transmit bit captured at the rising edge |
| tx_strobe_o | output | 1 | One-cycle pulse after each rising edge |
| rx_take_o | output | 1 | One-cycle pulse as each received bit is launched |

## Verification
The bench builds the block with DIV_W = 4, so the half-period count is four bits wide. Both ends of its range can then be reached in a short run: 0 (acting as 1, the clock toggling every cycle) and 15, the top value. Counts are changed in the middle of high phases, which shows that the phase under way keeps the old length while later phases take the new one. A bit transfer goes on at every edge throughout, so capture and launch are checked at every rate, including the fastest.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Level of the generated bit clock.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Single-cycle edge events, valid in the cycle before the clock toggles.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;

endpackage

// File: rtl/sdclk_phase_timer.sv
module sdclk_phase_timer
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_per_i,
  output logic             dclk_q,
  output edge_ev_t         ev
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  phase_e           ph_q;
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff_half;
  logic             last_cyc;

  // A count of zero would stall the clock, so it is raised to one.
  always_comb eff_half = (half_per_i == '0) ? ONE : half_per_i;

  always_comb last_cyc = (cnt_q == (half_q - ONE));

  always_comb begin
    ev.rise = last_cyc && (ph_q == PH_LOW);
    ev.fall = last_cyc && (ph_q == PH_HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_LOW;
      cnt_q  <= '0;
      half_q <= eff_half;
    end else if (last_cyc) begin
      cnt_q <= '0;
      if (ph_q == PH_HIGH) begin
        ph_q   <= PH_LOW;
        half_q <= eff_half;   // new rate adopted only as the clock falls
      end else begin
        ph_q <= PH_HIGH;
      end
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign dclk_q = ph_q;

endmodule

// File: rtl/sdclk_tx_capture.sv
module sdclk_tx_capture
  import sdclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  edge_ev_t ev,
  input  logic     txd_i,
  output logic     tx_bit_o,
  output logic     tx_strobe_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit_o    <= 1'b0;
      tx_strobe_o <= 1'b0;
    end else begin
      tx_strobe_o <= ev.rise;
      if (ev.rise) tx_bit_o <= txd_i;
    end
  end

endmodule

// File: rtl/sdclk_rx_launch.sv
module sdclk_rx_launch
  import sdclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  edge_ev_t ev,
  input  logic     rx_bit_i,
  output logic     rxd_o,
  output logic     rx_take_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_o     <= 1'b0;
      rx_take_o <= 1'b0;
    end else begin
      rx_take_o <= ev.fall;
      if (ev.fall) rxd_o <= rx_bit_i;
    end
  end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_per_i,
  input  logic             txd_i,
  input  logic             rx_bit_i,
  output logic             dclk_o,
  output logic             rxd_o,
  output logic             tx_bit_o,
  output logic             tx_strobe_o,
  output logic             rx_take_o
);

  edge_ev_t ev;

  sdclk_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .half_per_i (half_per_i),
    .dclk_q     (dclk_o),
    .ev         (ev)
  );

  sdclk_tx_capture u_tx (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .txd_i       (txd_i),
    .tx_bit_o    (tx_bit_o),
    .tx_strobe_o (tx_strobe_o)
  );

  sdclk_rx_launch u_rx (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .rx_bit_i  (rx_bit_i),
    .rxd_o     (rxd_o),
    .rx_take_o (rx_take_o)
  );

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic clk,
  input logic rst,
  input logic dclk_o,
  input logic rxd_o,
  input logic tx_bit_o,
  input logic tx_strobe_o,
  input logic rx_take_o
);

  // Independent phase-length measurement from the clock output alone.
  logic           prev_d;
  logic [DIV_W:0] run_q;
  logic [DIV_W:0] low_len_q;
  logic           seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_d    <= 1'b0;
      run_q     <= '0;
      low_len_q <= '0;
      seen_q    <= 1'b0;
    end else if (dclk_o != prev_d) begin
      prev_d <= dclk_o;
      run_q  <= (DIV_W+1)'(1);
      if (!prev_d) begin
        low_len_q <= run_q;
        seen_q    <= 1'b1;
      end
    end else begin
      run_q <= run_q + (DIV_W+1)'(1);
    end
  end

  AST_EQUAL_HALVES: assert property (@(posedge clk) disable iff (rst)
    (seen_q && prev_d && !dclk_o) |-> (run_q == low_len_q)); // R2

  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk_o) |-> tx_strobe_o); // R5

  AST_STROBE_ONLY_RISE: assert property (@(posedge clk) disable iff (rst)
    tx_strobe_o |-> $rose(dclk_o)); // R5

  AST_TAKE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(dclk_o) |-> rx_take_o); // R6

  AST_TAKE_ONLY_FALL: assert property (@(posedge clk) disable iff (rst)
    rx_take_o |-> $fell(dclk_o)); // R6

  AST_RXD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$fell(dclk_o) |-> $stable(rxd_o)); // R6

  AST_TXBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tx_strobe_o |-> $stable(tx_bit_o)); // R7

endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dclk_o      (dclk_o),
  .rxd_o       (rxd_o),
  .tx_bit_o    (tx_bit_o),
  .tx_strobe_o (tx_strobe_o),
  .rx_take_o   (rx_take_o)
);

// File: tb/sdclk_gen_test.sv
module sdclk_gen_test;

  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] half_per_i = DIV_W'(3);
  logic             txd_i = 1'b0;
  logic             rx_bit_i = 1'b0;
  logic             dclk_o, rxd_o, tx_bit_o, tx_strobe_o, rx_take_o;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  bit    finished = 1'b0;
  string cur_tag = "R2";

  logic exp_tx[$];
  logic exp_rx[$];

  always #5 clk = ~clk;

  sdclk_gen #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .half_per_i(half_per_i), .txd_i(txd_i),
    .rx_bit_i(rx_bit_i), .dclk_o(dclk_o), .rxd_o(rxd_o),
    .tx_bit_o(tx_bit_o), .tx_strobe_o(tx_strobe_o), .rx_take_o(rx_take_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input logic [DIV_W-1:0] h);
    return (h == '0) ? 1 : int'(h);
  endfunction

  // Driver: one bit each way per clock period, pushing expectations.
  task automatic xfer(input logic t, input logic r, input int newhalf);
    while (dclk_o !== 1'b0) @(negedge clk);
    txd_i = t;
    exp_tx.push_back(t);
    while (dclk_o !== 1'b1) @(negedge clk);
    if (newhalf >= 0) half_per_i = DIV_W'(newhalf);
    rx_bit_i = r;
    exp_rx.push_back(r);
    while (dclk_o !== 1'b0) @(negedge clk);
  endtask

  // Monitor: samples just after each edge and pops the scoreboard.
  initial begin
    logic prev_d = 1'b0;
    logic prev_rxd = 1'b0;
    logic prev_txb = 1'b0;
    int   phase_len = 0;
    int   exp_half = 0;
    bit   armed = 1'b0;
    logic popped;
    forever begin
      @(posedge clk);
      #1;
      if (rst || done) begin
        prev_d = dclk_o; prev_rxd = rxd_o; prev_txb = tx_bit_o;
        phase_len = 0; armed = 1'b0;
        continue;
      end
      if (dclk_o != prev_d) begin
        if (armed)
          check(phase_len == exp_half, {cur_tag, " R2 R4 phase length"}, phase_len, exp_half);
        if (!dclk_o) begin
          armed = 1'b1;
          exp_half = eff(half_per_i);
        end
        phase_len = 1;
      end else begin
        phase_len++;
      end
      // R5: strobe and captured bit at every rise, nowhere else
      if (dclk_o && !prev_d) begin
        check(tx_strobe_o == 1'b1, "R5 strobe at rise", tx_strobe_o, 1);
        if (exp_tx.size() == 0) begin
          check(1'b0, "R5 rise with no queued bit", 0, 1);
        end else begin
          popped = exp_tx.pop_front();
          check(tx_bit_o == popped, "R5 tx bit", tx_bit_o, popped);
        end
      end else begin
        check(tx_strobe_o == 1'b0, "R5 strobe away from rise", tx_strobe_o, 0);
        check(tx_bit_o == prev_txb, "R7 tx bit held", tx_bit_o, prev_txb);
      end
      // R6: launch and take pulse at every fall, rxd quiet otherwise
      if (!dclk_o && prev_d) begin
        check(rx_take_o == 1'b1, "R6 take at fall", rx_take_o, 1);
        if (exp_rx.size() == 0) begin
          check(1'b0, "R6 fall with no queued bit", 0, 1);
        end else begin
          popped = exp_rx.pop_front();
          check(rxd_o == popped, "R6 rxd value", rxd_o, popped);
        end
      end else begin
        check(rx_take_o == 1'b0, "R6 take away from fall", rx_take_o, 0);
        check(rxd_o == prev_rxd, "R6 rxd held", rxd_o, prev_rxd);
      end
      prev_d = dclk_o; prev_rxd = rxd_o; prev_txb = tx_bit_o;
    end
  end

  // Watchdog
  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    check(dclk_o == 1'b0, "R1 dclk", dclk_o, 0);
    check(rxd_o == 1'b0, "R1 rxd", rxd_o, 0);
    check(tx_bit_o == 1'b0, "R1 tx bit", tx_bit_o, 0);
    check(tx_strobe_o == 1'b0, "R1 strobe", tx_strobe_o, 0);
    check(rx_take_o == 1'b0, "R1 take", rx_take_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check({dclk_o, rxd_o, tx_bit_o, tx_strobe_o, rx_take_o} == 5'b0,
          "R1 first cycle after reset", int'({dclk_o, rxd_o, tx_bit_o, tx_strobe_o, rx_take_o}), 0);

    cur_tag = "R2";
    for (int i = 0; i < 8; i++) xfer(logic'(i % 2), logic'((i / 2) % 2), -1);

    cur_tag = "R4";
    xfer(1'b1, 1'b0, 5);
    for (int i = 0; i < 6; i++) xfer(logic'((i * 3 + 1) % 4 == 0), logic'(i % 3 == 0), -1);

    cur_tag = "R3";
    xfer(1'b0, 1'b1, 0);
    for (int i = 0; i < 10; i++) xfer(logic'((i * 5) % 3 == 1), logic'(i % 2), -1);

    cur_tag = "R8";
    xfer(1'b1, 1'b1, 15);
    for (int i = 0; i < 4; i++) xfer(logic'(i % 2 == 0), logic'(i > 1), -1);

    cur_tag = "R4";
    xfer(1'b0, 1'b0, 2);
    for (int i = 0; i < 6; i++) xfer(logic'(i % 3 != 0), logic'(i % 2 == 0), -1);

    done = 1'b1;
    repeat (4) @(negedge clk);
    check(exp_tx.size() == 0, "R5 tx queue drained", exp_tx.size(), 0);
    check(exp_rx.size() == 0, "R6 rx queue drained", exp_rx.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule